// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner Deserializer

This block sits behind a clock-and-data recovery stage. It takes one recovered serial bit on each cycle where `bit_en` is high and turns the stream into parallel words. Every frame is twelve bits long: a 1 framing bit, then ten data bits, then a 0 framing bit. Where the 0 closing one frame meets the 1 opening the next, the stream has a rising edge. That edge is the only one guaranteed to recur at the same position in every frame.

The aligner does not search for a fixed sync word. It keeps a set of candidate positions within the twelve-bit window. At the end of each window it removes every position that did not show a 0-to-1 transition. When exactly one position is left, the block declares lock by driving `lock_n` low, and it then emits one strobe per frame carrying the ten data bits. If the candidate set empties, or the boundary edge fails to appear after lock, alignment restarts with every position as a candidate.

An output enable hides the word outputs without touching alignment. An active-low power-down input clears the block and marks every output as undriven. The `*_oe` outputs stand in for the high-impedance state.

Top module: `fa_deser`

## Requirements
- R1: After reset: `lock_n`=1, `lock_oe`=1, `word_stb`=0 and `word_valid`=0, and `data_oe` follows `out_en`.
- R2: A frame is start 1, ten data bits, stop 0. When locked, `word_stb` pulses for one cycle after each accepted stop bit. `word_data[0]` holds the first data bit after the start bit and `word_data[9]` the last. Framing bits never appear in the word.
- R3: Lock by elimination: `lock_n` falls in the cycle after the last bit of the first complete window whose surviving candidate set has exactly one member. A sync stream of six 1s then six 0s, at any phase, locks within 42 word periods; from a frame-aligned start it locks after 12 bits.
- R4: If a data rising edge recurs at the same position in every frame, `lock_n` stays high. Elimination still resumes when later frames drop that position.
- R5: If the candidate set becomes empty at a window end, every position is restored as a candidate, so a following sync frame still locks.
- R6: After lock, a missing rising edge at the boundary position raises `lock_n` and clears `word_valid` in the cycle after that bit, and realignment starts.
- R7: `word_valid` is 0 on the first strobe after lock and 1 from the second strobe on, while lock holds.
- R8: With `out_en`=0, `data_oe`, `word_stb`, `word_valid` and `word_data` read 0. `lock_n` and the strobe cadence are unaffected, and after re-enable the next frame's word is correct and still valid.
- R9: With `pwr_n`=0, `lock_oe`, `data_oe` and `word_stb` read 0 and all state clears. After release, `lock_n`=1 and acquisition starts from scratch.
- R10: Cycles with `bit_en`=0 do not advance the frame; idle gaps inside a frame leave the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Recovered serial bit |
| pwr_n | input | 1 | Active-low power-down |
| out_en | input | 1 | Word output enable |
| lock_n | output | 1 | Active-low lock flag |
| lock_oe | output | 1 | `lock_n` is driven |
| word_stb | output | 1 | One-cycle word strobe |
| word_data | output | DATA_W | Deframed data word |
| word_valid | output | 1 | Word data is valid |
| data_oe | output | 1 | Word outputs are driven |

## Verification
The bench builds the block with its default `DATA_W` of 10, which gives a 12-bit frame and a 4-bit position counter. Frame-aligned streams put the boundary at position 0, so the stop position wraps to 11. A stream offset by five idle zeros puts the boundary at position 5 and the stop at position 4. With these defaults, a pair of alternating frames that share a permanent data edge keeps two candidates alive. An all-zero window empties the candidate set entirely.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int FA_MAX_FRAME = 32;

    typedef enum logic {
        FA_HUNT = 1'b0,
        FA_HOLD = 1'b1
    } fa_state_e;

    function automatic int unsigned fa_pop(input logic [FA_MAX_FRAME-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < FA_MAX_FRAME; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int unsigned fa_index(input logic [FA_MAX_FRAME-1:0] v);
        int unsigned k;
        k = 0;
        for (int i = 0; i < FA_MAX_FRAME; i++) if (v[i]) k = i;
        return k;
    endfunction

endpackage

// File: rtl/fa_bit_track.sv
module fa_bit_track #(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2,
    parameter int POS_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [POS_W-1:0]  pos,
    output logic              rise,
    output logic [DATA_W-1:0] span
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);

    logic prev_q;

    assign rise = bit_en & ~prev_q & bit_in;

    always_ff @(posedge clk) begin
        if (clr) begin
            pos    <= '0;
            prev_q <= 1'b0;
            span   <= '0;
        end else if (bit_en) begin
            prev_q <= bit_in;
            span   <= {span[DATA_W-2:0], bit_in};
            pos    <= (pos == LAST) ? '0 : pos + POS_W'(1);
        end
    end
endmodule

// File: rtl/fa_cand_elim.sv
module fa_cand_elim
    import fa_pkg::*;
#(
    parameter int FRAME_W = 12,
    parameter int POS_W   = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             bit_en,
    input  logic             rise,
    input  logic [POS_W-1:0] pos,
    output fa_state_e        state,
    output logic [POS_W-1:0] bnd_pos,
    output logic             drop
);
    localparam logic [POS_W-1:0]   LAST = POS_W'(FRAME_W - 1);
    localparam logic [FRAME_W-1:0] ONES = '1;

    logic [FRAME_W-1:0] cand_q, seen_q, rise_vec, seen_nx, cand_nx, upto;

    always_comb begin
        rise_vec = rise ? (FRAME_W'(1) << pos) : '0;
        seen_nx  = seen_q | rise_vec;
        cand_nx  = cand_q & seen_nx;
        upto     = (FRAME_W'(1) << pos) - FRAME_W'(1);
        drop     = bit_en && (state == FA_HOLD) && (pos == bnd_pos) && !rise;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cand_q  <= ONES;
            seen_q  <= '0;
            state   <= FA_HUNT;
            bnd_pos <= '0;
        end else if (bit_en) begin
            if (state == FA_HOLD) begin
                if (drop) begin
                    state  <= FA_HUNT;
                    cand_q <= ONES;
                    seen_q <= (pos == LAST) ? '0 : upto;
                end
            end else if (pos == LAST) begin
                seen_q <= '0;
                if (cand_nx == '0) begin
                    cand_q <= ONES;
                end else begin
                    cand_q <= cand_nx;
                    if (fa_pop(FA_MAX_FRAME'(cand_nx)) == 1) begin
                        state   <= FA_HOLD;
                        bnd_pos <= POS_W'(fa_index(FA_MAX_FRAME'(cand_nx)));
                    end
                end
            end else begin
                seen_q <= seen_nx;
            end
        end
    end
endmodule

// File: rtl/fa_word_out.sv
module fa_word_out
    import fa_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2,
    parameter int POS_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              bit_en,
    input  fa_state_e         state,
    input  logic              drop,
    input  logic [POS_W-1:0]  pos,
    input  logic [POS_W-1:0]  bnd_pos,
    input  logic [DATA_W-1:0] span,
    input  logic              out_en,
    input  logic              pwr_n,
    output logic              word_stb,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic              data_oe,
    output logic              lock_n,
    output logic              lock_oe
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);

    logic              stb_q, valid_q, seen_one_q;
    logic [DATA_W-1:0] data_q, word_nx;
    logic [POS_W-1:0]  stop_pos;

    assign stop_pos = (bnd_pos == '0) ? LAST : bnd_pos - POS_W'(1);

    always_comb begin
        for (int i = 0; i < DATA_W; i++) word_nx[i] = span[DATA_W-1-i];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            stb_q      <= 1'b0;
            valid_q    <= 1'b0;
            seen_one_q <= 1'b0;
            data_q     <= '0;
        end else begin
            stb_q <= 1'b0;
            if (state != FA_HOLD || drop) begin
                valid_q    <= 1'b0;
                seen_one_q <= 1'b0;
            end else if (bit_en && pos == stop_pos) begin
                stb_q      <= 1'b1;
                data_q     <= word_nx;
                seen_one_q <= 1'b1;
                if (seen_one_q) valid_q <= 1'b1;
            end
        end
    end

    assign data_oe    = out_en & pwr_n;
    assign word_stb   = stb_q & data_oe;
    assign word_valid = valid_q & data_oe;
    assign word_data  = data_oe ? data_q : '0;
    assign lock_n     = (state != FA_HOLD);
    assign lock_oe    = pwr_n;
endmodule

// File: rtl/fa_deser.sv
module fa_deser
    import fa_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              pwr_n,
    input  logic              out_en,
    output logic              lock_n,
    output logic              lock_oe,
    output logic              word_stb,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic              data_oe
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int POS_W   = $clog2(FRAME_W);

    logic              clr, rise, drop;
    logic [POS_W-1:0]  pos, bnd_pos;
    logic [DATA_W-1:0] span;
    fa_state_e         state;

    assign clr = rst | ~pwr_n;

    fa_bit_track #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .POS_W(POS_W)) u_track (
        .clk(clk), .clr(clr), .bit_en(bit_en), .bit_in(bit_in),
        .pos(pos), .rise(rise), .span(span)
    );

    fa_cand_elim #(.FRAME_W(FRAME_W), .POS_W(POS_W)) u_elim (
        .clk(clk), .clr(clr), .bit_en(bit_en), .rise(rise), .pos(pos),
        .state(state), .bnd_pos(bnd_pos), .drop(drop)
    );

    fa_word_out #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .POS_W(POS_W)) u_out (
        .clk(clk), .clr(clr), .bit_en(bit_en), .state(state), .drop(drop),
        .pos(pos), .bnd_pos(bnd_pos), .span(span), .out_en(out_en), .pwr_n(pwr_n),
        .word_stb(word_stb), .word_data(word_data), .word_valid(word_valid),
        .data_oe(data_oe), .lock_n(lock_n), .lock_oe(lock_oe)
    );
endmodule

// File: rtl/fa_deser_chk.sv
module fa_deser_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic pwr_n,
    input logic lock_n,
    input logic word_stb,
    input logic word_valid
);
    AST_STB_LOCKED: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> !lock_n); // R2
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb); // R2
    AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> $past(bit_en)); // R3
    AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> !lock_n); // R7
    AST_PWRDN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !pwr_n |=> (lock_n && !word_stb)); // R9
    AST_STB_ON_BIT: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> $past(bit_en)); // R10
endmodule

bind fa_deser fa_deser_chk u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pwr_n(pwr_n),
    .lock_n(lock_n), .word_stb(word_stb), .word_valid(word_valid)
);

// File: tb/sim_fa_deser.sv
module sim_fa_deser;
    localparam int CLK_P = 10;
    localparam int DW    = 10;
    // {serial order (bit 9 sent first), expected word}
    localparam logic [19:0] VEC [8] = '{
        {10'b1000000000, 10'h001},
        {10'b0000000001, 10'h200},
        {10'b1100000000, 10'h003},
        {10'b1010101010, 10'h155},
        {10'b0011110000, 10'h03C},
        {10'b1111111111, 10'h3FF},
        {10'b0000000000, 10'h000},
        {10'b1110001101, 10'h2C7}
    };

    logic clk = 0, rst = 1, bit_en = 0, bit_in = 0, pwr_n = 1, out_en = 1;
    logic lock_n, lock_oe, word_stb, word_valid, data_oe;
    logic [DW-1:0] word_data;

    int tests = 0, fails = 0, stb_cnt = 0;
    logic [DW-1:0] last_word = '0;
    logic last_valid = 0, done = 0;

    always #(CLK_P/2) clk = ~clk;

    fa_deser #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .pwr_n(pwr_n),
        .out_en(out_en), .lock_n(lock_n), .lock_oe(lock_oe), .word_stb(word_stb),
        .word_data(word_data), .word_valid(word_valid), .data_oe(data_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        if (word_stb) begin
            stb_cnt++;
            last_word  = word_data;
            last_valid = word_valid;
        end
    endtask

    task automatic send_bit(input logic b, input int gap);
        for (int g = 0; g < gap; g++) begin bit_en = 0; bit_in = ~b; tick(); end
        bit_in = b; bit_en = 1; tick(); bit_en = 0;
    endtask

    task automatic send_frame(input logic [9:0] ser, input logic stop, input int gap);
        send_bit(1'b1, gap);
        for (int i = 9; i >= 0; i--) send_bit(ser[i], gap);
        send_bit(stop, gap);
    endtask

    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    function automatic logic stream_bit(input int j);
        if (j < 5) return 1'b0;
        return ((j - 5) % 12) < 6;
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s0, nbits;
        do_reset();
        // R1 reset state
        chk(lock_n == 1 && lock_oe == 1 && word_stb == 0 && word_valid == 0 && data_oe == 1,
            "R1", {lock_n, lock_oe, word_stb, word_valid, data_oe}, 5'b11001);

        // R3 aligned sync locks after one window
        send_frame(10'b1111100000, 1'b0, 0);
        chk(lock_n == 0, "R3", lock_n, 0);
        s0 = stb_cnt;
        send_frame(10'b1111100000, 1'b0, 0);
        chk(stb_cnt == s0 + 1 && last_valid == 0, "R7", {stb_cnt - s0, last_valid}, 2);
        chk(last_word == 10'h01F, "R2", last_word, 10'h01F);
        send_frame(10'b1111100000, 1'b0, 0);
        chk(stb_cnt == s0 + 2 && last_valid == 1, "R7", {stb_cnt - s0, last_valid}, 5);

        // R2 / R10 vector table, odd entries with idle gaps
        for (int i = 0; i < 8; i++) begin
            s0 = stb_cnt;
            send_frame(VEC[i][19:10], 1'b0, i % 2);
            chk(stb_cnt == s0 + 1 && last_word == VEC[i][9:0] && last_valid == 1,
                (i % 2) ? "R10" : "R2", last_word, VEC[i][9:0]);
        end

        // R8 output enable masks words only
        out_en = 0; s0 = stb_cnt;
        send_frame(10'b1110001101, 1'b0, 0);
        chk(stb_cnt == s0 && word_data == 0 && data_oe == 0 && word_valid == 0,
            "R8", stb_cnt - s0, 0);
        chk(lock_n == 0, "R8", lock_n, 0);
        out_en = 1;
        send_frame(10'b1000000000, 1'b0, 0);
        chk(stb_cnt == s0 + 1 && last_word == 10'h001 && last_valid == 1, "R8", last_word, 10'h001);

        // R6 missing boundary edge
        send_frame(10'b0000000000, 1'b1, 0);
        send_bit(1'b1, 0);
        chk(lock_n == 1 && word_valid == 0, "R6", {lock_n, word_valid}, 2);
        for (int i = 1; i < 12; i++) send_bit(i < 6, 0);
        chk(lock_n == 1, "R5", lock_n, 1);
        send_frame(10'b1111100000, 1'b0, 0);
        chk(lock_n == 0, "R5", lock_n, 0);

        // R4 permanent data edge
        do_reset();
        for (int f = 0; f < 8; f++)
            send_frame((f % 2) ? 10'b0111111111 : 10'b0100000000, 1'b0, 0);
        chk(lock_n == 1, "R4", lock_n, 1);
        send_frame(10'b1111100000, 1'b0, 0);
        chk(lock_n == 0, "R4", lock_n, 0);

        // R5 empty candidate set
        do_reset();
        for (int i = 0; i < 12; i++) send_bit(1'b0, 0);
        chk(lock_n == 1, "R5", lock_n, 1);
        send_frame(10'b1111100000, 1'b0, 0);
        chk(lock_n == 0, "R5", lock_n, 0);

        // R9 power-down
        pwr_n = 0; s0 = stb_cnt;
        for (int i = 0; i < 14; i++) send_bit(i % 3 == 0, 0);
        chk(lock_oe == 0 && data_oe == 0 && stb_cnt == s0, "R9", {lock_oe, data_oe}, 0);
        pwr_n = 1; tick();
        chk(lock_n == 1 && lock_oe == 1, "R9", {lock_n, lock_oe}, 3);
        nbits = 0;
        while (lock_n == 1 && nbits < 504) begin send_bit(stream_bit(nbits), 0); nbits++; end
        chk(nbits <= 504, "R3", nbits, 504);
        chk(nbits == 12, "R3", nbits, 12);
        s0 = stb_cnt;
        for (int j = nbits; j < 29; j++) send_bit(stream_bit(j), 0);
        chk(stb_cnt == s0 + 2 && last_valid == 1 && last_word == 10'h01F, "R9", last_word, 10'h01F);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule